// File: doc/BRIEF.md
# UART Transmit Start and Interrupt Shaping Control

This block sits beside one UART channel and decides two things: when the transmitter may begin shifting out a freshly written character, and what the channel's interrupt request pin shows. It takes a strobe for each write to the transmit holding register, a bit-time reference tick, the shifter's busy flag, the holding register's empty flag, the receive FIFO fill count, a base receive threshold and a combined request from the channel's other interrupt sources. It drives a one-clock transmit start pulse and the IRQ pin level.

A small configuration register is loaded from dedicated inputs on a load strobe. One field lets the start be held back by one bit time. Another field chooses whether "transmit empty" means only the holding register or the holding register together with the shifter. A further field scales the receive trigger level by 1, 2, 4 or 8. The last fields choose the electrical style of the IRQ pin when the pin is shared with other devices. The shifter, the FIFOs and the baud generator live outside this block.

Top module: `uart_txirq_ctrl`

## Requirements
- R1: After reset every configuration field is 0, `txStart` is low and `irqOut` is low. The fields change only in a clock where `cfgLoad` is high.
- R2: With the delay field at 0, a holding-register write sampled at edge k sets a pending start. `txStart` is then high for exactly one clock after the first edge k+n (n ≥ 1) at which `shiftBusy` is sampled low, and the pending start clears.
- R3: With the delay field at 1, the write loads a delay count of OVERSAMPLE. Each sampled `bitTick` lowers it by one. The start of R2 is withheld until the count has reached zero.
- R4: A holding-register write sampled while a start is still pending has no effect. It neither reloads the delay count nor produces a second start pulse.
- R5: With the interrupt-mode field at 0, the transmit interrupt condition is `thrEmpty`. With the field at 1, it is `thrEmpty` with `shiftBusy` low.
- R6: The receive trigger level is `rxBase` shifted left by the scale code (00 → ×1, 01 → ×2, 10 → ×4, 11 → ×8), capped at FIFO_DEPTH. The receive condition is true when `rxBase` is nonzero and `rxCount` is at least this level.
- R7: The combined condition is the OR of the transmit condition, the receive condition and `extIrq`.
- R8: With the share field at 0, `irqOut` follows the combined condition one clock later, active high, regardless of the style field.
- R9: With sharing on and style 00, `irqOut` is the inverse of the combined condition, one clock later.
- R10: With sharing on and style 10, `irqOut` equals the combined condition, one clock later.
- R11: With sharing on and style 01, `irqOut` is high for exactly one clock after each edge at which the combined condition is sampled high, having been sampled low at the edge before.
- R12: With sharing on and the reserved style 11, `irqOut` is held high, which is the inactive level of the active-low style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Load the configuration fields below |
| cfgTxDelay | input | 1 | 1 = hold the start back by one bit time |
| cfgTxIntMode | input | 1 | 1 = transmit empty also needs the shifter idle |
| cfgThrScale | input | 2 | Receive threshold scale code |
| cfgIrqStyle | input | 2 | Shared-pin style: 00 low level, 01 high pulse, 10 high level, 11 reserved |
| cfgIrqShare | input | 1 | 1 = apply the shared-pin style |
| thrWrite | input | 1 | Holding-register write strobe |
| bitTick | input | 1 | Oversampling tick, OVERSAMPLE per bit time |
| shiftBusy | input | 1 | Transmit shifter is busy |
| thrEmpty | input | 1 | Transmit holding register is empty |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxBase | input | CNT_W | Base receive threshold, 0 disables |
| extIrq | input | 1 | Other interrupt sources of the channel, ORed |
| txStart | output | 1 | One-clock start pulse to the shifter |
| irqOut | output | 1 | Interrupt pin drive |

## Verification
Starts are driven with the shifter idle, with the shifter held busy across the write, in delayed mode with a slow tick, and with a second write landing inside the delay. Together these separate the immediate path, the idle wait, the full bit-time count and the absorbed rewrite. The receive level is swept through every count from empty to full under each scale code, with a base large enough to hit the cap, so that both sides of each boundary are seen. The pin styles are each driven by the same train of short and long `extIrq` pulses. This distinguishes inversion, level following, single-clock edge pulses (one per rising edge, none on long highs) and the stuck-inactive reserved code.

// File: rtl/uart_txirq_pkg.sv
package uart_txirq_pkg;

  typedef enum logic [1:0] {
    IRQ_LOW_LEVEL  = 2'b00,
    IRQ_HIGH_EDGE  = 2'b01,
    IRQ_HIGH_LEVEL = 2'b10,
    IRQ_RESERVED   = 2'b11
  } irqStyle_e;

  // Settings handed from the control half to the datapath half.
  typedef struct packed {
    logic      txIntMode;
    logic [1:0] thrScale;
    logic      irqShare;
    irqStyle_e irqStyle;
  } ctlBus_t;

endpackage

// File: rtl/uart_txirq_ctl.sv
module uart_txirq_ctl
  import uart_txirq_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgLoad,
  input  logic       cfgTxDelay,
  input  logic       cfgTxIntMode,
  input  logic [1:0] cfgThrScale,
  input  logic [1:0] cfgIrqStyle,
  input  logic       cfgIrqShare,
  input  logic       thrWrite,
  input  logic       bitTick,
  input  logic       shiftBusy,
  output logic       txStart,
  output logic       dlyActive,
  output ctlBus_t    ctlBus
);

  localparam int DLY_W = $clog2(OVERSAMPLE + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(OVERSAMPLE);

  logic            delayQ;
  ctlBus_t         busQ;
  logic            reqQ;
  logic [DLY_W-1:0] dlyCnt;
  logic            startQ;
  logic            fireNow;

  // Configuration register, all fields cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      delayQ         <= 1'b0;
      busQ.txIntMode <= 1'b0;
      busQ.thrScale  <= 2'b00;
      busQ.irqShare  <= 1'b0;
      busQ.irqStyle  <= IRQ_LOW_LEVEL;
    end else if (cfgLoad) begin
      delayQ         <= cfgTxDelay;
      busQ.txIntMode <= cfgTxIntMode;
      busQ.thrScale  <= cfgThrScale;
      busQ.irqShare  <= cfgIrqShare;
      busQ.irqStyle  <= irqStyle_e'(cfgIrqStyle);
    end
  end

  // A start fires once the request is pending, the delay has run out
  // and the shifter is free.
  assign fireNow = reqQ && (dlyCnt == '0) && !shiftBusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ   <= 1'b0;
      dlyCnt <= '0;
      startQ <= 1'b0;
    end else begin
      startQ <= fireNow;
      if (thrWrite && !reqQ) begin
        reqQ   <= 1'b1;
        dlyCnt <= delayQ ? DLY_LOAD : '0;
      end else begin
        if (fireNow) begin
          reqQ <= 1'b0;
        end
        if (bitTick && (dlyCnt != '0)) begin
          dlyCnt <= dlyCnt - 1'b1;
        end
      end
    end
  end

  assign txStart   = startQ;
  assign dlyActive = (dlyCnt != '0);
  assign ctlBus    = busQ;

endmodule

// File: rtl/uart_txirq_dp.sv
module uart_txirq_dp
  import uart_txirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlBus_t          ctlBus,
  input  logic             thrEmpty,
  input  logic             shiftBusy,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxBase,
  input  logic             extIrq,
  output logic [CNT_W-1:0] scaledThr,
  output logic             irqOut
);

  localparam int WIDE_W = CNT_W + 3;
  localparam logic [WIDE_W-1:0] DEPTH_WIDE = WIDE_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0]  DEPTH_CNT  = CNT_W'(FIFO_DEPTH);

  logic [WIDE_W-1:0] wideThr;
  logic txHit, rxHit, condNow;
  logic condQ, irqQ, irqNext;

  // Threshold scaling with a cap at the FIFO depth.
  assign wideThr   = {3'b000, rxBase} << ctlBus.thrScale;
  assign scaledThr = (wideThr > DEPTH_WIDE) ? DEPTH_CNT : wideThr[CNT_W-1:0];

  assign rxHit   = (rxBase != '0) && (rxCount >= scaledThr);
  assign txHit   = ctlBus.txIntMode ? (thrEmpty && !shiftBusy) : thrEmpty;
  assign condNow = txHit || rxHit || extIrq;

  // Pin shaping.
  always_comb begin
    if (!ctlBus.irqShare) begin
      irqNext = condNow;
    end else begin
      unique case (ctlBus.irqStyle)
        IRQ_LOW_LEVEL:  irqNext = !condNow;
        IRQ_HIGH_EDGE:  irqNext = condNow && !condQ;
        IRQ_HIGH_LEVEL: irqNext = condNow;
        default:        irqNext = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      condQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      condQ <= condNow;
      irqQ  <= irqNext;
    end
  end

  assign irqOut = irqQ;

endmodule

// File: rtl/uart_txirq_ctrl.sv
module uart_txirq_ctrl
  import uart_txirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgLoad,
  input  logic             cfgTxDelay,
  input  logic             cfgTxIntMode,
  input  logic [1:0]       cfgThrScale,
  input  logic [1:0]       cfgIrqStyle,
  input  logic             cfgIrqShare,
  input  logic             thrWrite,
  input  logic             bitTick,
  input  logic             shiftBusy,
  input  logic             thrEmpty,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxBase,
  input  logic             extIrq,
  output logic             txStart,
  output logic             irqOut
);

  ctlBus_t          ctlBus;
  logic             dlyActive;
  logic [CNT_W-1:0] scaledThr;

  uart_txirq_ctl #(.OVERSAMPLE(OVERSAMPLE)) i_ctl (
    .clk(clk), .rst(rst),
    .cfgLoad(cfgLoad), .cfgTxDelay(cfgTxDelay), .cfgTxIntMode(cfgTxIntMode),
    .cfgThrScale(cfgThrScale), .cfgIrqStyle(cfgIrqStyle), .cfgIrqShare(cfgIrqShare),
    .thrWrite(thrWrite), .bitTick(bitTick), .shiftBusy(shiftBusy),
    .txStart(txStart), .dlyActive(dlyActive), .ctlBus(ctlBus)
  );

  uart_txirq_dp #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .ctlBus(ctlBus),
    .thrEmpty(thrEmpty), .shiftBusy(shiftBusy),
    .rxCount(rxCount), .rxBase(rxBase), .extIrq(extIrq),
    .scaledThr(scaledThr), .irqOut(irqOut)
  );

endmodule

// File: rtl/uart_txirq_chk.sv
module uart_txirq_chk
  import uart_txirq_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    shiftBusy,
  input logic    extIrq,
  input logic    txStart,
  input logic    irqOut,
  input logic    dlyActive,
  input ctlBus_t ctlBus
);

  logic edgeMode, rsvdMode, plainMode;
  assign edgeMode  = ctlBus.irqShare && (ctlBus.irqStyle == IRQ_HIGH_EDGE);
  assign rsvdMode  = ctlBus.irqShare && (ctlBus.irqStyle == IRQ_RESERVED);
  assign plainMode = !ctlBus.irqShare;

  // A start is only issued when the shifter was seen idle.
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (txStart && !$past(rst)) |-> !$past(shiftBusy));

  // No start leaves while the bit-time delay is still counting.
  assert_no_early_start_R3: assert property (@(posedge clk) disable iff (rst)
    dlyActive |=> !txStart);

  // Edge style never gives two high clocks in a row.
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (irqOut && !$past(rst) && $past(edgeMode) && $past(edgeMode, 2)) |-> !$past(irqOut));

  // Reserved style keeps the pin at its inactive high level.
  assert_reserved_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rsvdMode)) |-> irqOut);

  // Unshared pin follows any other source as an active-high level.
  assert_plain_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(plainMode) && $past(extIrq)) |-> irqOut);

endmodule

bind uart_txirq_ctrl uart_txirq_chk i_chk (
  .clk(clk), .rst(rst), .shiftBusy(shiftBusy), .extIrq(extIrq),
  .txStart(txStart), .irqOut(irqOut), .dlyActive(dlyActive), .ctlBus(ctlBus)
);

// File: tb/test_uart_txirq_ctrl.sv
`timescale 1ns/1ps
module test_uart_txirq_ctrl;

  localparam int DEPTH = 16;
  localparam int OVS   = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgLoad = 0, cfgTxDelay = 0, cfgTxIntMode = 0, cfgIrqShare = 0;
  logic [1:0] cfgThrScale = 0, cfgIrqStyle = 0;
  logic thrWrite = 0, bitTick = 0, shiftBusy = 0, thrEmpty = 0, extIrq = 0;
  logic [CW-1:0] rxCount = 0, rxBase = 0;
  logic txStart, irqOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit tickEn = 0;
  int tickDiv = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_txirq_ctrl #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(OVS)) i_uart_txirq_ctrl (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgTxDelay(cfgTxDelay),
    .cfgTxIntMode(cfgTxIntMode), .cfgThrScale(cfgThrScale), .cfgIrqStyle(cfgIrqStyle),
    .cfgIrqShare(cfgIrqShare), .thrWrite(thrWrite), .bitTick(bitTick),
    .shiftBusy(shiftBusy), .thrEmpty(thrEmpty), .rxCount(rxCount), .rxBase(rxBase),
    .extIrq(extIrq), .txStart(txStart), .irqOut(irqOut)
  );

  // Behavioural reference model, stepped on every rising edge.
  bit mDelay, mIntMode, mShare, mReq, mStart, mIrq, mPrev;
  int mScale, mStyle, mCnt;
  bit txC, rxC, cond;
  int thr;

  always @(posedge clk) begin
    if (rst) begin
      mDelay = 0; mIntMode = 0; mShare = 0; mScale = 0; mStyle = 0;
      mReq = 0; mStart = 0; mIrq = 0; mPrev = 0; mCnt = 0;
    end else begin
      txC = mIntMode ? (thrEmpty && !shiftBusy) : thrEmpty;
      thr = int'(rxBase) * (1 << mScale);
      if (thr > DEPTH) thr = DEPTH;
      rxC = (rxBase != 0) && (int'(rxCount) >= thr);
      cond = txC || rxC || extIrq;
      if (!mShare) mIrq = cond;
      else case (mStyle)
        0: mIrq = !cond;
        1: mIrq = cond && !mPrev;
        2: mIrq = cond;
        default: mIrq = 1;
      endcase
      mPrev = cond;
      mStart = mReq && (mCnt == 0) && !shiftBusy;
      if (thrWrite && !mReq) begin
        mReq = 1;
        mCnt = mDelay ? OVS : 0;
      end else begin
        if (mStart) mReq = 0;
        if (bitTick && mCnt > 0) mCnt--;
      end
      if (cfgLoad) begin
        mDelay = cfgTxDelay; mIntMode = cfgTxIntMode; mShare = cfgIrqShare;
        mScale = int'(cfgThrScale); mStyle = int'(cfgIrqStyle);
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (txStart !== mStart) begin
        errors++;
        $display("FAIL %s txStart actual %0b expected %0b at %0t", curReq, txStart, mStart, $time);
      end
      checks++;
      if (irqOut !== mIrq) begin
        errors++;
        $display("FAIL %s irqOut actual %0b expected %0b at %0t", curReq, irqOut, mIrq, $time);
      end
    end
  end

  // Bit tick: one pulse every third clock while enabled.
  always @(negedge clk) begin
    tickDiv = (tickDiv == 2) ? 0 : tickDiv + 1;
    bitTick = tickEn && (tickDiv == 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCfg(input bit d, input bit im, input int sc, input int st, input bit sh);
    @(negedge clk);
    cfgTxDelay = d; cfgTxIntMode = im; cfgThrScale = 2'(sc);
    cfgIrqStyle = 2'(st); cfgIrqShare = sh; cfgLoad = 1;
    @(negedge clk);
    cfgLoad = 0;
    cfgTxDelay = 0; cfgTxIntMode = 0; cfgThrScale = 0; cfgIrqStyle = 0; cfgIrqShare = 0;
  endtask

  task automatic writeThr();
    @(negedge clk);
    thrWrite = 1;
    @(negedge clk);
    thrWrite = 0;
  endtask

  task automatic pulseTrain();
    extIrq = 1; cyc(1); extIrq = 0; cyc(2);
    extIrq = 1; cyc(5); extIrq = 0; cyc(3);
    extIrq = 1; cyc(2); extIrq = 0; cyc(4);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired in %s", curReq);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    // R1: reset state and cleared fields; stray config inputs without load.
    curReq = "R1";
    cfgIrqShare = 1; cfgIrqStyle = 2'b11; cfgTxDelay = 1;
    cyc(4);
    cfgIrqShare = 0; cfgIrqStyle = 0; cfgTxDelay = 0;
    thrEmpty = 1; cyc(3); thrEmpty = 0; cyc(2);

    // R2: immediate start, idle and busy shifter.
    curReq = "R2";
    writeThr(); cyc(5);
    shiftBusy = 1; writeThr(); cyc(6); shiftBusy = 0; cyc(4);

    // R3: one bit-time delay.
    curReq = "R3";
    loadCfg(1, 0, 0, 0, 0);
    tickEn = 1;
    writeThr(); cyc(60);
    shiftBusy = 1; writeThr(); cyc(55); shiftBusy = 0; cyc(5);

    // R4: rewrite inside the delay is absorbed.
    curReq = "R4";
    writeThr(); cyc(20); writeThr(); cyc(40);
    tickEn = 0;
    loadCfg(0, 0, 0, 0, 0);
    writeThr(); writeThr(); cyc(5);

    // R5: two transmit-empty definitions.
    curReq = "R5";
    thrEmpty = 1; shiftBusy = 1; cyc(4); shiftBusy = 0; cyc(3);
    loadCfg(0, 1, 0, 0, 0);
    shiftBusy = 1; cyc(4); shiftBusy = 0; cyc(3); thrEmpty = 0; cyc(3);
    loadCfg(0, 0, 0, 0, 0);

    // R6: threshold scaling and cap, swept across every count.
    curReq = "R6";
    for (int sc = 0; sc < 4; sc++) begin
      loadCfg(0, 0, sc, 0, 0);
      rxBase = 3;
      for (int c = 0; c <= DEPTH; c++) begin
        rxCount = CW'(c); cyc(2);
      end
      rxBase = 10;
      for (int c = 8; c <= DEPTH; c++) begin
        rxCount = CW'(c); cyc(2);
      end
      rxBase = 0; rxCount = CW'(DEPTH); cyc(2);
      rxCount = 0;
    end

    // R7: combined condition from each source.
    curReq = "R7";
    loadCfg(0, 0, 0, 0, 0);
    pulseTrain();
    rxBase = 4; rxCount = 5; cyc(3); rxCount = 0; rxBase = 0;
    thrEmpty = 1; extIrq = 1; cyc(3); thrEmpty = 0; extIrq = 0; cyc(2);

    // R8: sharing off, style field ignored.
    curReq = "R8";
    loadCfg(0, 0, 0, 1, 0); pulseTrain();
    loadCfg(0, 0, 0, 3, 0); pulseTrain();

    curReq = "R9";
    loadCfg(0, 0, 0, 0, 1); pulseTrain();
    curReq = "R10";
    loadCfg(0, 0, 0, 2, 1); pulseTrain();
    curReq = "R11";
    loadCfg(0, 0, 0, 1, 1); pulseTrain();
    thrEmpty = 1; cyc(6); thrEmpty = 0; cyc(2);
    curReq = "R12";
    loadCfg(0, 0, 0, 3, 1); pulseTrain();
    loadCfg(0, 0, 0, 0, 0); cyc(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule